// File: doc/BRIEF.md
# Graceful Stop and Interrupt Controller

This block gathers the event, interrupt and DMA-control logic of an Ethernet DMA engine. It keeps a sixteen-bit event register whose bits are cleared by writing ones, an enable mask of the same width, and a three-bit control word. From these it drives three interrupt lines: one for transmit, one for receive and one for errors.

A graceful stop is requested by writing the control word. A receive or transmit stop request completes at once when no frame is in flight in that direction. When a frame is in flight, completion waits for that frame's end strobe. Completion shows up as an event bit in the error group.

Writing the control word with wait-on-poll clear starts a periodic ticker. On each tick it asks the descriptor logic to poll transmit ring 0, unless a graceful transmit stop is in force. The tick period is a parameter in clock cycles. Its default gives 100 Hz from the clock rate.

Top module: `dma_stop_irq_ctrl`

## Requirements
- R1: After reset the event, mask and control registers are zero, all three interrupt lines and `tx_poll_o` are low, and the ticker is idle.
- R2: A one on `evt_set_i[b]` sets event bit b at the next edge. Bit 0 forms the transmit group, bit 1 the receive group, and bits 2 to 15 the error group. A group's line rises at that same edge when the bit's mask enable is set. The mask is written with `wr_sel_i`=1.
- R3: A write with `wr_sel_i`=0 clears every event bit whose data bit is one. After such a write the transmit line is low if bit 0 is clear, and the receive line is low if bit 1 is clear.
- R4: The error line stays high while any event bit from 2 to 15 remains set, and goes low only once all of them are clear.
- R5: A set event whose mask enable is clear does not raise its line. Enabling the mask while the event is pending raises the line at the edge of that mask write.
- R6: When an event bit is cleared by a write and strobed in the same cycle, it ends up set.
- R7: A control write (`wr_sel_i`=2) with bit 0 (receive stop) set while `rx_busy_i` is low sets event bit 3 at that edge.
- R8: If `rx_busy_i` is high at that write, event bit 3 is set only at the edge where `rx_end_i` is seen. An `rx_end_i` with no pending stop sets nothing.
- R9: Control bit 1 (transmit stop) behaves the same way, using `tx_busy_i`, `tx_end_i` and event bit 2, whether the stop completes at once or is deferred.
- R10: A control write with bit 2 (wait-on-poll) clear restarts the ticker. `tx_poll_o` then pulses for one cycle every POLL_CYC cycles, and the first pulse comes POLL_CYC edges after the write edge.
- R11: A tick that finds control bit 2 set produces no pulse and stops the ticker.
- R12: A tick that finds control bit 1 set produces no pulse, but the ticker keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 events (clear by ones), 1 mask, 2 control, 3 none |
| wr_data_i | input | 16 | Write data |
| evt_set_i | input | 16 | Raw event strobes, one per event bit |
| tx_busy_i | input | 1 | Transmit frame in progress |
| rx_busy_i | input | 1 | Receive frame in progress |
| tx_end_i | input | 1 | Transmit frame ended (one-cycle strobe) |
| rx_end_i | input | 1 | Receive frame ended (one-cycle strobe) |
| tx_irq_o | output | 1 | Transmit interrupt line |
| rx_irq_o | output | 1 | Receive interrupt line |
| err_irq_o | output | 1 | Error interrupt line |
| tx_poll_o | output | 1 | Request to poll transmit ring 0 (one-cycle pulse) |

## Verification
The hardest case to reach is the deferred graceful stop. It needs a frame held in progress across the control write, a quiet stretch during which no completion may appear, and then the end strobe. The bench holds the busy input high, issues the stop, checks the error line over several idle cycles, and only then pulses the end strobe. It repeats this for both directions. Event bits are not readable, so the bench observes them through the lines. It narrows the mask to one bit, or enables the mask afterwards, to show that an event was latched while its line stayed low.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int EVT_W    = 16;
  localparam int CTL_W    = 3;
  localparam int EV_TSTOP = 2;
  localparam int EV_RSTOP = 3;
  localparam logic [EVT_W-1:0] TX_GRP  = 16'h0001;
  localparam logic [EVT_W-1:0] RX_GRP  = 16'h0002;
  localparam logic [EVT_W-1:0] ERR_GRP = 16'hFFFC;
  localparam int CT_RSTOP = 0;
  localparam int CT_TSTOP = 1;
  localparam int CT_WOP   = 2;
  typedef enum logic [1:0] {
    SEL_EVT  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/evt_irq_bank.sv
module evt_irq_bank
  import dsi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] set_i,
  input  logic             clr_we_i,
  input  logic             mask_we_i,
  input  logic [EVT_W-1:0] data_i,
  output logic [2:0]       irq_o
);
  localparam logic [3*EVT_W-1:0] GRPS = {ERR_GRP, RX_GRP, TX_GRP};

  logic [EVT_W-1:0] evt_q, evt_n, mask_q, mask_n;

  always_comb begin
    evt_n  = (clr_we_i ? (evt_q & ~data_i) : evt_q) | set_i;  // set wins
    mask_n = mask_we_i ? data_i : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q  <= evt_n;
      mask_q <= mask_n;
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_line
    localparam logic [EVT_W-1:0] GRP = GRPS[g*EVT_W +: EVT_W];
    logic line_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      line_q <= 1'b0;
      else if (|(evt_n & mask_n & GRP)) line_q <= 1'b1;
      else if (!(|(evt_n & GRP)))       line_q <= 1'b0;
    end
    assign irq_o[g] = line_q;
  end

  a_r3_tx_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(evt_q & TX_GRP)) |-> !irq_o[0]);
  a_r3_rx_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(evt_q & RX_GRP)) |-> !irq_o[1]);
  a_r4_err_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_q & ERR_GRP) == '0) |-> !irq_o[2]);
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((evt_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/gstop_unit.sv
module gstop_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic busy_i,
  input  logic end_i,
  output logic done_o
);
  logic pend_q;
  logic now_done, late_done;

  assign now_done  = req_i & ~busy_i;
  assign late_done = pend_q & end_i;
  assign done_o    = now_done | late_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_q <= 1'b0;
    else if (req_i && busy_i) pend_q <= 1'b1;
    else if (late_done)       pend_q <= 1'b0;
  end

  a_r8_no_early_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !end_i && !req_i) |-> !done_o);
  a_r8_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !end_i) |=> pend_q);
endmodule

// File: rtl/poll_ticker.sv
module poll_ticker #(
  parameter int POLL_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic wop_i,
  input  logic gts_i,
  output logic poll_o
);
  localparam int CNT_W = (POLL_CYC > 2) ? $clog2(POLL_CYC) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(POLL_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      poll_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= RELOAD;
      run_q  <= 1'b1;
      poll_o <= 1'b0;
    end else if (run_q && cnt_q == '0) begin
      if (!wop_i) begin
        poll_o <= ~gts_i;
        cnt_q  <= RELOAD;
      end else begin
        poll_o <= 1'b0;
        run_q  <= 1'b0;
      end
    end else begin
      poll_o <= 1'b0;
      if (run_q) cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_o |=> !poll_o);
  a_r12_gated_by_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_o |-> !$past(gts_i));
  a_r11_gated_by_wop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_o |-> !$past(wop_i));
endmodule

// File: rtl/dma_stop_irq_ctrl.sv
module dma_stop_irq_ctrl
  import dsi_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int POLL_HZ  = 100,
  parameter int POLL_CYC = CLK_HZ / POLL_HZ
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [EVT_W-1:0] wr_data_i,
  input  logic [EVT_W-1:0] evt_set_i,
  input  logic             tx_busy_i,
  input  logic             rx_busy_i,
  input  logic             tx_end_i,
  input  logic             rx_end_i,
  output logic             tx_irq_o,
  output logic             rx_irq_o,
  output logic             err_irq_o,
  output logic             tx_poll_o
);
  logic             ctl_we, evt_we, mask_we;
  logic [CTL_W-1:0] ctl_q;
  logic [1:0]       stop_req, stop_busy, stop_end, stop_done;
  logic [EVT_W-1:0] set_all;
  logic [2:0]       irq;

  assign evt_we  = wr_en_i && (wr_sel_i == SEL_EVT);
  assign mask_we = wr_en_i && (wr_sel_i == SEL_MASK);
  assign ctl_we  = wr_en_i && (wr_sel_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (ctl_we) ctl_q <= wr_data_i[CTL_W-1:0];
  end

  // index 0 transmit, 1 receive
  assign stop_req  = {ctl_we & wr_data_i[CT_RSTOP], ctl_we & wr_data_i[CT_TSTOP]};
  assign stop_busy = {rx_busy_i, tx_busy_i};
  assign stop_end  = {rx_end_i, tx_end_i};

  for (genvar d = 0; d < 2; d++) begin : g_stop
    gstop_unit u_stop (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (stop_req[d]),
      .busy_i (stop_busy[d]),
      .end_i  (stop_end[d]),
      .done_o (stop_done[d])
    );
  end

  always_comb begin
    set_all           = evt_set_i;
    set_all[EV_TSTOP] = evt_set_i[EV_TSTOP] | stop_done[0];
    set_all[EV_RSTOP] = evt_set_i[EV_RSTOP] | stop_done[1];
  end

  evt_irq_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_all),
    .clr_we_i  (evt_we),
    .mask_we_i (mask_we),
    .data_i    (wr_data_i),
    .irq_o     (irq)
  );

  assign tx_irq_o  = irq[0];
  assign rx_irq_o  = irq[1];
  assign err_irq_o = irq[2];

  poll_ticker #(.POLL_CYC(POLL_CYC)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (ctl_we & ~wr_data_i[CT_WOP]),
    .wop_i     (ctl_q[CT_WOP]),
    .gts_i     (ctl_q[CT_TSTOP]),
    .poll_o    (tx_poll_o)
  );

  a_r7_rx_stop_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we && wr_data_i[CT_RSTOP] && !rx_busy_i) |-> stop_done[1]);
  a_r9_tx_stop_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we && wr_data_i[CT_TSTOP] && !tx_busy_i) |-> stop_done[0]);
endmodule

// File: tb/tb_dma_stop_irq_ctrl.sv
module tb_dma_stop_irq_ctrl;
  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] evt_set = '0;
  logic        tx_busy = 1'b0, rx_busy = 1'b0, tx_end = 1'b0, rx_end = 1'b0;
  logic        tx_irq, rx_irq, err_irq, tx_poll;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    string      tag;
    logic [2:0] exp;  // {err, rx, tx}
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  dma_stop_irq_ctrl #(.POLL_CYC(P)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .evt_set_i(evt_set), .tx_busy_i(tx_busy),
    .rx_busy_i(rx_busy), .tx_end_i(tx_end), .rx_end_i(rx_end),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq), .err_irq_o(err_irq),
    .tx_poll_o(tx_poll)
  );

  // monitor: pops expectations and compares against the lines
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        n_tests++;
        if ({err_irq, rx_irq, tx_irq} !== it.exp) begin
          n_fail++;
          $display("FAIL %s: lines {err,rx,tx} actual %b expected %b",
                   it.tag, {err_irq, rx_irq, tx_irq}, it.exp);
        end
      end
    end
  end

  task automatic expect_lines(input string tag, input logic [2:0] e);
    exp_t it;
    it.tag = tag;
    it.exp = e;
    sb_q.push_back(it);
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic strobe(input logic [15:0] v);
    evt_set = v;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic count_poll(input int n, output int cnt, output int first);
    cnt = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (tx_poll) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int c, f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_lines("R1 reset lines", 3'b000);
    chk_int("R1 reset poll", int'(tx_poll), 0);
    count_poll(3 * P, c, f);
    chk_int("R1 ticker idle", c, 0);

    wr(2'd1, 16'hFFFF);
    strobe(16'h0001);
    expect_lines("R2 tx event", 3'b001);
    strobe(16'h0002);
    expect_lines("R2 rx event", 3'b011);
    wr(2'd0, 16'h0001);
    expect_lines("R3 tx cleared", 3'b010);

    strobe(16'h0410);
    expect_lines("R2 err events", 3'b110);
    wr(2'd0, 16'h0010);
    expect_lines("R4 one err left", 3'b110);
    wr(2'd0, 16'h0400);
    expect_lines("R4 all err clear", 3'b010);

    // set wins: clear rx bit while strobing it
    evt_set = 16'h0002;
    wr(2'd0, 16'h0002);
    evt_set = '0;
    expect_lines("R6 set wins", 3'b010);
    wr(2'd0, 16'h0002);
    expect_lines("R3 rx cleared", 3'b000);

    wr(2'd1, 16'h0002);
    strobe(16'h0020);
    expect_lines("R5 masked off", 3'b000);
    wr(2'd1, 16'hFFFF);
    expect_lines("R5 mask enable raises", 3'b100);
    wr(2'd0, 16'h0020);
    expect_lines("R4 cleared", 3'b000);

    // receive graceful stop, immediate
    wr(2'd1, 16'h0008);
    wr(2'd2, 16'h0005);
    expect_lines("R7 rx stop now", 3'b100);
    wr(2'd0, 16'h0008);
    expect_lines("R7 cleared", 3'b000);

    // receive graceful stop, deferred
    rx_busy = 1'b1;
    wr(2'd2, 16'h0005);
    expect_lines("R8 deferred", 3'b000);
    repeat (5) @(negedge clk);
    expect_lines("R8 still waiting", 3'b000);
    rx_end = 1'b1; @(negedge clk); rx_end = 1'b0;
    expect_lines("R8 frame end completes", 3'b100);
    wr(2'd0, 16'h0008);
    rx_busy = 1'b0;
    rx_end = 1'b1; @(negedge clk); rx_end = 1'b0;
    expect_lines("R8 stray end ignored", 3'b000);

    // transmit graceful stop
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0006);
    expect_lines("R9 tx stop masked", 3'b000);
    wr(2'd1, 16'h0004);
    expect_lines("R9 tx stop now", 3'b100);
    wr(2'd0, 16'h0004);
    tx_busy = 1'b1;
    wr(2'd2, 16'h0006);
    repeat (4) @(negedge clk);
    expect_lines("R9 tx deferred", 3'b000);
    tx_end = 1'b1; @(negedge clk); tx_end = 1'b0;
    expect_lines("R9 tx frame end", 3'b100);
    wr(2'd0, 16'h0004);
    tx_busy = 1'b0;
    wr(2'd1, 16'h0000);

    // poll ticker
    wr(2'd2, 16'h0000);
    count_poll(4 * P, c, f);
    chk_int("R10 pulse count", c, 4);
    chk_int("R10 first pulse", f, P);

    wr(2'd2, 16'h0002);
    count_poll(3 * P, c, f);
    chk_int("R12 gated by tx stop", c, 0);
    wr(2'd2, 16'h0004);
    count_poll(3 * P, c, f);
    chk_int("R11 stopped by wait-on-poll", c, 0);

    wr(2'd2, 16'h0000);
    count_poll(2 * P, c, f);
    chk_int("R10 restart first pulse", f, P);
    chk_int("R10 restart count", c, 2);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule